// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block decides when a newly written gain code reaches each of two audio channels. A write stores a pending code. Depending on the mode, that code is either applied at once or held back. When it is held back, each channel applies it at its own next zero crossing of the digitized signal, or when a timeout counted in sample periods runs out, whichever comes first. The left and right channels wait independently, so they may switch on different samples.

A second, narrower preamp gain code goes through the same mechanism with a fixed timeout. This wait is skipped when the converter is unpowered, because no signal is then present to cross zero. Zero crossings are detected from the two's-complement samples that come with a per-sample strobe. The detector compares each sample's sign bit with the sign bit of the previous strobed sample on the same channel.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset both applied main gain codes are 28h (unity) and both applied preamp codes are 2'b10; the stored previous sign of each channel is 0 (positive).
- R2: A channel sees a zero crossing on a strobed sample whose bit 19 (sign) differs from that of the previous strobed sample of that channel, or whose value is exactly zero.
- R3: With `zc_en` low, a main gain write is visible on both `gain_l` and `gain_r` in the clock cycle after the write.
- R4: With `zc_en` high, a written main gain is held back per channel until that channel's zero crossing or until 256 << `tmo_sel` strobes (`tmo_sel` 0..3 gives 256, 512, 1024, 2048) have been counted since the write, applying on the strobe that completes the count.
- R5: A written main code above 60h is stored and applied as 60h, so an applied main gain never exceeds 60h.
- R6: A write while a channel is still waiting replaces its pending code and restarts its strobe count from zero.
- R7: With `adc_pwr` high, a preamp write is held back per channel until that channel's zero crossing or 2048 strobes, whatever `tmo_sel` and `zc_en` are.
- R8: With `adc_pwr` low, a preamp write is visible on both preamp outputs in the cycle after the write.
- R9: If the wait condition is dropped (`zc_en` or `adc_pwr` goes low) while a channel is waiting, its pending code is applied on the next clock edge.
- R10: A zero crossing on one channel applies the pending code on that channel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| smp_l | input | 20 | Left sample, two's complement, valid with strobe |
| smp_r | input | 20 | Right sample, two's complement, valid with strobe |
| gain_wr | input | 1 | Main gain write pulse |
| gain_code | input | 7 | Main gain code to write |
| zc_en | input | 1 | 1: main gain waits for zero crossing/timeout |
| tmo_sel | input | 2 | Main gain timeout select |
| pre_wr | input | 1 | Preamp gain write pulse |
| pre_code | input | 2 | Preamp gain code to write |
| adc_pwr | input | 1 | Converter powered; 1 makes the preamp code wait |
| gain_l | output | 7 | Applied left main gain |
| gain_r | output | 7 | Applied right main gain |
| pre_l | output | 2 | Applied left preamp gain |
| pre_r | output | 2 | Applied right preamp gain |

## Verification
The case hardest to reach from the ports is a timeout that expires on exactly the last counted strobe. To get there, the previous-sign state of both channels must first be set by a strobe, and no sample afterwards may be zero or change sign. The stimulus first sends a settling strobe of +1 on both channels and then holds that value for hundreds or thousands of strobes. It checks the output one strobe before and one strobe after the boundary. It reaches the restart case the same way, with a second write placed in the middle of the count.

// File: rtl/zcg_pkg.sv
// Package: shared constants and helpers for the zero-crossing gain controller.
// Assumes a 7-bit main code with a 60h ceiling and a 2-bit preamp code.
package zcg_pkg;
    localparam int unsigned GAIN_W   = 7;
    localparam int unsigned PRE_W    = 2;
    localparam logic [GAIN_W-1:0] GAIN_CEIL = 7'h60;
    localparam logic [GAIN_W-1:0] GAIN_RST  = 7'h28;
    localparam logic [PRE_W-1:0]  PRE_RST   = 2'b10;
    localparam int unsigned NUM_CH   = 2;

    // Limit a requested main gain code to the highest legal code.
    function automatic logic [GAIN_W-1:0] clamp_gain(input logic [GAIN_W-1:0] c);
        return (c > GAIN_CEIL) ? GAIN_CEIL : c;
    endfunction
endpackage

// File: rtl/zcg_zero_detect.sv
// Zero-crossing detector for one channel.
// Flags a crossing on a strobed sample whose sign differs from the previous
// strobed sample, or which is exactly zero. Assumes the sample is stable
// during the strobe cycle.
module zcg_zero_detect #(
    parameter int unsigned SMP_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [SMP_W-1:0] sample,
    output logic             zc
);
    logic prev_sign;

    // Remember the sign of the most recent strobed sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   prev_sign <= 1'b0;
        else if (stb) prev_sign <= sample[SMP_W-1];
    end

    // Crossing flag, valid only in a strobe cycle.
    always_comb begin
        zc = stb && ((sample == '0) || (sample[SMP_W-1] != prev_sign));
    end

    a_r2_zero_is_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sample == '0) |-> zc);
    a_r2_no_strobe_no_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> !zc);
endmodule

// File: rtl/zcg_slot.sv
// Pending/applied register pair for one code on one channel.
// A write either applies at once (wait_en low) or arms a wait that ends on a
// crossing or when the strobe count reaches 'limit'. A write always wins over
// a strobe in the same cycle. Assumes limit >= 1.
module zcg_slot #(
    parameter int unsigned W     = 7,
    parameter int unsigned LIM_W = 12,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             zc,
    input  logic             wr,
    input  logic [W-1:0]     wr_code,
    input  logic             wait_en,
    input  logic [LIM_W-1:0] limit,
    output logic [W-1:0]     applied
);
    localparam int unsigned CNT_W = LIM_W - 1;

    logic [W-1:0]     pend;
    logic             waiting;
    logic [CNT_W-1:0] cnt;
    logic             last;

    // The strobe being handled completes the timeout count.
    always_comb begin
        last = ({1'b0, cnt} + 1'b1) >= limit;
    end

    // Write capture, wait tracking and application of the pending code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= RST_VAL;
            applied <= RST_VAL;
            waiting <= 1'b0;
            cnt     <= '0;
        end else if (wr) begin
            pend <= wr_code;
            cnt  <= '0;
            if (wait_en) begin
                waiting <= 1'b1;
            end else begin
                applied <= wr_code;
                waiting <= 1'b0;
            end
        end else if (waiting) begin
            if (!wait_en || (stb && (zc || last))) begin
                applied <= pend;
                waiting <= 1'b0;
                cnt     <= '0;
            end else if (stb) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r3_immediate_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wait_en) |=> (applied == $past(wr_code)));
    a_r9_wait_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !wait_en && !wr) |=> (!waiting && applied == $past(pend)));
    a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && wait_en && !wr && !stb) |=> $stable(applied));
    a_r6_write_arms_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wait_en) |=> (waiting && cnt == '0));
endmodule

// File: rtl/zc_gain_ctrl.sv
// Top: two-channel zero-crossing gain update controller.
// Each channel has a crossing detector, a main gain slot with selectable
// timeout and a preamp slot with a fixed timeout. Writes go to both
// channels; application is independent per channel.
module zc_gain_ctrl
    import zcg_pkg::*;
#(
    parameter int unsigned SMP_W    = 20,
    parameter int unsigned TMO_BASE = 256,
    parameter int unsigned PRE_TMO  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [SMP_W-1:0]  smp_l,
    input  logic [SMP_W-1:0]  smp_r,
    input  logic              gain_wr,
    input  logic [GAIN_W-1:0] gain_code,
    input  logic              zc_en,
    input  logic [1:0]        tmo_sel,
    input  logic              pre_wr,
    input  logic [PRE_W-1:0]  pre_code,
    input  logic              adc_pwr,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r,
    output logic [PRE_W-1:0]  pre_l,
    output logic [PRE_W-1:0]  pre_r
);
    localparam int unsigned TMO_TOP = TMO_BASE * 8;
    localparam int unsigned LIM_W   = $clog2(TMO_TOP) + 1;

    logic [SMP_W-1:0]  smp_a  [NUM_CH];
    logic [GAIN_W-1:0] gain_a [NUM_CH];
    logic [PRE_W-1:0]  pre_a  [NUM_CH];
    logic [GAIN_W-1:0] code_cl;
    logic [LIM_W-1:0]  main_lim;
    logic [LIM_W-1:0]  pre_lim;

    assign smp_a[0] = smp_l;
    assign smp_a[1] = smp_r;
    assign gain_l   = gain_a[0];
    assign gain_r   = gain_a[1];
    assign pre_l    = pre_a[0];
    assign pre_r    = pre_a[1];

    // Clamp the written code and derive both timeout limits.
    always_comb begin
        code_cl  = clamp_gain(gain_code);
        main_lim = LIM_W'(TMO_BASE) << tmo_sel;
        pre_lim  = LIM_W'(PRE_TMO);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic zc;

        zcg_zero_detect #(.SMP_W(SMP_W)) i_det (
            .clk(clk), .rst_n(rst_n), .stb(smp_stb),
            .sample(smp_a[ch]), .zc(zc)
        );

        zcg_slot #(.W(GAIN_W), .LIM_W(LIM_W), .RST_VAL(GAIN_RST)) i_main (
            .clk(clk), .rst_n(rst_n), .stb(smp_stb), .zc(zc),
            .wr(gain_wr), .wr_code(code_cl), .wait_en(zc_en),
            .limit(main_lim), .applied(gain_a[ch])
        );

        zcg_slot #(.W(PRE_W), .LIM_W(LIM_W), .RST_VAL(PRE_RST)) i_pre (
            .clk(clk), .rst_n(rst_n), .stb(smp_stb), .zc(zc),
            .wr(pre_wr), .wr_code(pre_code), .wait_en(adc_pwr),
            .limit(pre_lim), .applied(pre_a[ch])
        );

        a_r5_gain_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            gain_a[ch] <= GAIN_CEIL);
    end
endmodule

// File: tb/test_zc_gain_ctrl.sv
// Bench: vector table walk followed by directed timeout, preamp and mode tests.
module test_zc_gain_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_stb;
    logic [19:0] smp_l, smp_r;
    logic        gain_wr;
    logic [6:0]  gain_code;
    logic        zc_en;
    logic [1:0]  tmo_sel;
    logic        pre_wr;
    logic [1:0]  pre_code;
    logic        adc_pwr;
    logic [6:0]  gain_l, gain_r;
    logic [1:0]  pre_l, pre_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    zc_gain_ctrl i_zc_gain_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
        .gain_wr(gain_wr), .gain_code(gain_code), .zc_en(zc_en), .tmo_sel(tmo_sel),
        .pre_wr(pre_wr), .pre_code(pre_code), .adc_pwr(adc_pwr),
        .gain_l(gain_l), .gain_r(gain_r), .pre_l(pre_l), .pre_r(pre_r)
    );

    // Vector: wr, code, zc_en, stb, left, right, expected left, expected right
    localparam int NV = 12;
    localparam logic [63:0] VEC [NV] = '{
        {1'b1, 7'h30, 1'b0, 1'b0, 20'd0,       20'd0,       7'h30, 7'h30}, // R3
        {1'b1, 7'h7F, 1'b0, 1'b0, 20'd0,       20'd0,       7'h60, 7'h60}, // R5
        {1'b1, 7'h10, 1'b1, 1'b0, 20'd0,       20'd0,       7'h60, 7'h60}, // R4 wait
        {1'b0, 7'h00, 1'b1, 1'b1, 20'd5,       20'd7,       7'h60, 7'h60}, // R2 no cross
        {1'b0, 7'h00, 1'b1, 1'b1, 20'hFFFFD,   20'd2,       7'h10, 7'h60}, // R10 left sign
        {1'b0, 7'h00, 1'b1, 1'b1, 20'hFFFFF,   20'd0,       7'h10, 7'h10}, // R2 zero
        {1'b1, 7'h20, 1'b1, 1'b0, 20'd0,       20'd0,       7'h10, 7'h10},
        {1'b0, 7'h00, 1'b1, 1'b1, 20'd4,       20'd1,       7'h20, 7'h10}, // R10
        {1'b1, 7'h40, 1'b1, 1'b0, 20'd0,       20'd0,       7'h20, 7'h10}, // R6 replace
        {1'b0, 7'h00, 1'b1, 1'b1, 20'd2,       20'd3,       7'h20, 7'h10},
        {1'b0, 7'h00, 1'b1, 1'b1, 20'hFFFFE,   20'hFFFFB,   7'h40, 7'h40}, // R6
        {1'b1, 7'h00, 1'b0, 1'b0, 20'd0,       20'd0,       7'h00, 7'h00}  // R3 mute
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive idle inputs at a falling edge.
    task automatic idle();
        smp_stb = 1'b0; gain_wr = 1'b0; pre_wr = 1'b0;
    endtask

    // Let one rising edge pass, return at the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic strobes(input int n, input logic [19:0] l, input logic [19:0] r);
        for (int i = 0; i < n; i++) begin
            smp_stb = 1'b1; smp_l = l; smp_r = r;
            tick();
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle(); smp_l = '0; smp_r = '0; gain_code = '0;
        zc_en = 1'b0; tmo_sel = 2'b11; pre_code = '0; adc_pwr = 1'b1;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 gain_l", gain_l, 'h28);
        chk("R1 gain_r", gain_r, 'h28);
        chk("R1 pre_l", pre_l, 2);
        chk("R1 pre_r", pre_r, 2);

        // Table walk: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            gain_wr = VEC[v][63]; gain_code = VEC[v][62:56]; zc_en = VEC[v][55];
            smp_stb = VEC[v][54]; smp_l = VEC[v][53:34]; smp_r = VEC[v][33:14];
            tick();
            chk($sformatf("R2/R3/R4/R5/R6/R10 vec%0d left", v), gain_l, VEC[v][13:7]);
            chk($sformatf("R2/R3/R4/R5/R6/R10 vec%0d right", v), gain_r, VEC[v][6:0]);
        end

        // R4 timeout at 256 strobes (tmo_sel 00)
        zc_en = 1'b1; tmo_sel = 2'b00;
        strobes(1, 20'd1, 20'd1);
        gain_wr = 1'b1; gain_code = 7'h50; tick();
        strobes(255, 20'd1, 20'd1);
        chk("R4 before 256th strobe", gain_l, 'h00);
        strobes(1, 20'd1, 20'd1);
        chk("R4 on 256th strobe left", gain_l, 'h50);
        chk("R4 on 256th strobe right", gain_r, 'h50);

        // R6 rewrite restarts count
        gain_wr = 1'b1; gain_code = 7'h11; tick();
        strobes(200, 20'd1, 20'd1);
        gain_wr = 1'b1; gain_code = 7'h22; tick();
        strobes(255, 20'd1, 20'd1);
        chk("R6 restarted count not done", gain_l, 'h50);
        strobes(1, 20'd1, 20'd1);
        chk("R6 replaced code applied", gain_r, 'h22);

        // R7 preamp fixed 2048 timeout, independent of tmo_sel
        adc_pwr = 1'b1;
        pre_wr = 1'b1; pre_code = 2'b01; tick();
        strobes(2047, 20'd1, 20'd1);
        chk("R7 preamp before 2048", pre_l, 2);
        strobes(1, 20'd1, 20'd1);
        chk("R7 preamp at 2048", pre_l, 1);
        // R7 / R10 preamp zero crossing per channel
        pre_wr = 1'b1; pre_code = 2'b11; tick();
        strobes(1, 20'hFFFFF, 20'd1);
        chk("R7 preamp left crossing", pre_l, 3);
        chk("R10 preamp right unchanged", pre_r, 1);
        strobes(1, 20'hFFFFF, 20'd0);
        chk("R7 preamp right zero", pre_r, 3);

        // R8 preamp immediate when unpowered
        adc_pwr = 1'b0;
        pre_wr = 1'b1; pre_code = 2'b00; tick();
        chk("R8 preamp immediate left", pre_l, 0);
        chk("R8 preamp immediate right", pre_r, 0);

        // R9 dropping zc_en while waiting
        zc_en = 1'b1; tmo_sel = 2'b11;
        gain_wr = 1'b1; gain_code = 7'h33; tick();
        chk("R9 still waiting", gain_l, 'h22);
        zc_en = 1'b0; tick();
        chk("R9 applied after drop left", gain_l, 'h33);
        chk("R9 applied after drop right", gain_r, 'h33);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule